// File: doc/BRIEF.md
# Packet FIFO with Forwarding Modes

This block is a single-clock buffer for packet streams. Beats arrive on a valid/ready write side carrying data plus start-of-packet, end-of-packet and error markers, and leave in the same order on a valid/ready read side with the same markers. A word-addressed register port exposes the current occupancy and holds four settings: an almost-full level, an almost-empty level, a forwarding threshold and a drop-on-error switch. Two flags compare the occupancy against the two levels.

The forwarding threshold picks the release policy at run time. When it is zero, the block works as store-and-forward: nothing is offered downstream until at least one packet has been completely written. When it is non-zero, the block works as cut-through: the first beat of a packet is offered once the occupancy reaches the threshold. After that, the rest of the packet follows whenever a beat is present, until its end-of-packet beat. In store-and-forward mode, the drop switch makes the block discard every packet whose closing beat is flagged as errored. It does this by rewinding the write position to the first beat of that packet.

The read side is run by a two-state machine. HUNT means no packet is in progress, and the release policy decides whether the head beat is offered. FLOW means a packet is in progress, and any stored beat is offered. Transition HUNT→FLOW is taken when a beat that is not an end-of-packet beat is delivered. Transition FLOW→HUNT is taken when an end-of-packet beat is delivered. A single-beat packet leaves the machine in HUNT.

Top module: `pkt_fifo`

## Requirements
- R1: Register word 0 returns the occupancy (beats held, including those of an unfinished incoming packet) in bits 23:0, with bits 31:24 zero; after reset it reads 0.
- R2: Word 2 is the almost-full level, read/write, reset value DEPTH-1; word 3 is the almost-empty level, read/write, reset value 0; both hold bits 23:0 and read back with bits 31:24 zero.
- R3: `almost_full` is high exactly when occupancy >= word 2; `almost_empty` is high exactly when occupancy <= word 3; a register write affects the flags from the following cycle.
- R4: `in_ready` is high exactly when occupancy < DEPTH; it is high after reset.
- R5: Beats leave in arrival order with data, start, end and error markers unchanged; a beat offered but not taken stays offered and unchanged; nothing is offered when empty.
- R6: With word 4 equal to 0 (store-and-forward), in HUNT `out_valid` is high only while at least one complete packet (end-of-packet beat written and not yet delivered) is stored.
- R7: With word 4 non-zero (cut-through), in HUNT `out_valid` is high only while occupancy >= word 4.
- R8: In FLOW, `out_valid` is high whenever occupancy is non-zero, regardless of the threshold or mode.
- R9: With word 5 bit 0 set and word 4 equal to 0, a packet whose end-of-packet beat has the error marker is removed entirely (occupancy falls by the beats already written); with word 4 non-zero the errored packet is delivered normally.
- R10: Word 1 and words 6 and 7 read 0; writes to words 0, 1, 6 and 7 change nothing.
- R11: Word 4 is read/write in bits 23:0 with reset value 0; word 5 bit 0 is read/write with reset 0, and its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Write-side beat valid |
| in_ready | output | 1 | Write-side room available |
| in_data | input | DATA_W | Write-side beat data |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_err | input | 1 | Error marker, meaningful on the last beat |
| out_valid | output | 1 | Read-side beat offered |
| out_ready | input | 1 | Read-side beat accepted |
| out_data | output | DATA_W | Read-side beat data |
| out_sop | output | 1 | First-beat marker of offered beat |
| out_eop | output | 1 | Last-beat marker of offered beat |
| out_err | output | 1 | Error marker of offered beat |
| almost_full | output | 1 | Occupancy at or above word 2 |
| almost_empty | output | 1 | Occupancy at or below word 3 |
| csr_addr | input | 3 | Register word address |
| csr_write | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr`, combinational |

## Verification
The bench builds the block with DEPTH = 8 and DATA_W = 8. At this depth, two four-beat packets fill the buffer completely, so the full boundary of `in_ready` and the almost-full flag at its reset level of 7 can be reached in a few cycles. A cut-through threshold of 3 is close enough to the depth that the FLOW state can be drained to zero occupancy mid-packet and then refilled below the threshold. With a small depth, the store-and-forward drop sequence (three good beats, four errored beats, two good beats) also rewinds the write position across the wrap of the pointers during the longer mixed runs.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;

    localparam int CSR_AW = 3;
    localparam int CSR_DW = 32;
    localparam int THR_W  = 24;

    localparam logic [CSR_AW-1:0] REG_LEVEL = 3'd0;
    localparam logic [CSR_AW-1:0] REG_SPARE = 3'd1;
    localparam logic [CSR_AW-1:0] REG_HIGH  = 3'd2;
    localparam logic [CSR_AW-1:0] REG_LOW   = 3'd3;
    localparam logic [CSR_AW-1:0] REG_FWD   = 3'd4;
    localparam logic [CSR_AW-1:0] REG_DROP  = 3'd5;

    typedef enum logic {
        RD_HUNT,
        RD_FLOW
    } rd_state_e;

endpackage

// File: rtl/pkt_fifo_csr.sv
module pkt_fifo_csr
    import pkt_fifo_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int FILL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic              csr_write,
    input  logic [CSR_DW-1:0] csr_wdata,
    output logic [CSR_DW-1:0] csr_rdata,
    input  logic [FILL_W-1:0] fill,
    output logic [THR_W-1:0]  hi_lvl,
    output logic [THR_W-1:0]  lo_lvl,
    output logic [THR_W-1:0]  fwd_thr,
    output logic              drop_en
);

    logic unused_wdata_top;
    assign unused_wdata_top = ^csr_wdata[CSR_DW-1:THR_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_lvl  <= THR_W'(DEPTH - 1);
            lo_lvl  <= '0;
            fwd_thr <= '0;
            drop_en <= 1'b0;
        end else if (csr_write) begin
            case (csr_addr)
                REG_HIGH: hi_lvl  <= csr_wdata[THR_W-1:0];
                REG_LOW:  lo_lvl  <= csr_wdata[THR_W-1:0];
                REG_FWD:  fwd_thr <= csr_wdata[THR_W-1:0];
                REG_DROP: drop_en <= csr_wdata[0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (csr_addr)
            REG_LEVEL: csr_rdata = CSR_DW'(fill);
            REG_HIGH:  csr_rdata = CSR_DW'(hi_lvl);
            REG_LOW:   csr_rdata = CSR_DW'(lo_lvl);
            REG_FWD:   csr_rdata = CSR_DW'(fwd_thr);
            REG_DROP:  csr_rdata = CSR_DW'(drop_en);
            default:   csr_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pkt_fifo_store.sv
module pkt_fifo_store #(
    parameter  int DATA_W = 8,
    parameter  int DEPTH  = 16,
    localparam int AW     = $clog2(DEPTH),
    localparam int FILL_W = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic              wr_err,
    input  logic              drop_mode,
    input  logic              rd_en,
    output logic [DATA_W-1:0] hd_data,
    output logic              hd_sop,
    output logic              hd_eop,
    output logic              hd_err,
    output logic [FILL_W-1:0] fill,
    output logic [FILL_W-1:0] pkt_cnt
);

    localparam int EW    = DATA_W + 3;
    localparam int B_SOP = DATA_W;
    localparam int B_EOP = DATA_W + 1;
    localparam int B_ERR = DATA_W + 2;

    logic [EW-1:0]     mem [DEPTH];
    logic [FILL_W-1:0] wr_ptr, rd_ptr, pkt_base;
    logic [EW-1:0]     head;
    logic              discard, closes, retires;

    assign discard = wr_en && wr_eop && wr_err && drop_mode;
    assign closes  = wr_en && wr_eop && !discard;
    assign retires = rd_en && hd_eop;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr[AW-1:0]] <= {wr_err, wr_eop, wr_sop, wr_data};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            pkt_base <= '0;
        end else if (discard) begin
            wr_ptr   <= pkt_base;
        end else if (wr_en) begin
            wr_ptr   <= wr_ptr + 1'b1;
            if (wr_eop) begin
                pkt_base <= wr_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (rd_en) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_cnt <= '0;
        end else begin
            case ({closes, retires})
                2'b10:   pkt_cnt <= pkt_cnt + 1'b1;
                2'b01:   pkt_cnt <= pkt_cnt - 1'b1;
                default: pkt_cnt <= pkt_cnt;
            endcase
        end
    end

    assign fill    = wr_ptr - rd_ptr;
    assign head    = mem[rd_ptr[AW-1:0]];
    assign hd_data = head[DATA_W-1:0];
    assign hd_sop  = head[B_SOP];
    assign hd_eop  = head[B_EOP];
    assign hd_err  = head[B_ERR];

endmodule

// File: rtl/pkt_fifo_rdctl.sv
module pkt_fifo_rdctl
    import pkt_fifo_pkg::*;
#(
    parameter int FILL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] fill,
    input  logic [FILL_W-1:0] pkt_cnt,
    input  logic [THR_W-1:0]  fwd_thr,
    input  logic              hd_eop,
    input  logic              out_ready,
    output logic              out_valid,
    output logic              rd_en
);

    rd_state_e state, state_nx;
    logic      have_beat;

    assign have_beat = (fill != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RD_HUNT;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        out_valid = 1'b0;
        state_nx  = state;
        unique case (state)
            RD_HUNT: begin
                if (!have_beat) begin
                    out_valid = 1'b0;
                end else if (fwd_thr == '0) begin
                    out_valid = (pkt_cnt != '0);
                end else begin
                    out_valid = (THR_W'(fill) >= fwd_thr);
                end
                if (out_valid && out_ready && !hd_eop) begin
                    state_nx = RD_FLOW;
                end
            end
            RD_FLOW: begin
                out_valid = have_beat;
                if (out_valid && out_ready && hd_eop) begin
                    state_nx = RD_HUNT;
                end
            end
        endcase
        rd_en = out_valid && out_ready;
    end

endmodule

// File: rtl/pkt_fifo.sv
module pkt_fifo
    import pkt_fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_err,
    output logic              almost_full,
    output logic              almost_empty,
    input  logic [2:0]        csr_addr,
    input  logic              csr_write,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata
);

    localparam int AW     = $clog2(DEPTH);
    localparam int FILL_W = AW + 1;

    logic [FILL_W-1:0] fill_lvl, pkt_cnt;
    logic [THR_W-1:0]  hi_lvl, lo_lvl, ct_thr;
    logic              drop_en, wr_en, rd_en, drop_mode;

    assign in_ready  = (fill_lvl < FILL_W'(DEPTH));
    assign wr_en     = in_valid && in_ready;
    assign drop_mode = drop_en && (ct_thr == '0);

    assign almost_full  = (THR_W'(fill_lvl) >= hi_lvl);
    assign almost_empty = (THR_W'(fill_lvl) <= lo_lvl);

    pkt_fifo_csr #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .csr_addr (csr_addr),
        .csr_write(csr_write),
        .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata),
        .fill     (fill_lvl),
        .hi_lvl   (hi_lvl),
        .lo_lvl   (lo_lvl),
        .fwd_thr  (ct_thr),
        .drop_en  (drop_en)
    );

    pkt_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (in_data),
        .wr_sop   (in_sop),
        .wr_eop   (in_eop),
        .wr_err   (in_err),
        .drop_mode(drop_mode),
        .rd_en    (rd_en),
        .hd_data  (out_data),
        .hd_sop   (out_sop),
        .hd_eop   (out_eop),
        .hd_err   (out_err),
        .fill     (fill_lvl),
        .pkt_cnt  (pkt_cnt)
    );

    pkt_fifo_rdctl #(.FILL_W(FILL_W)) u_rdctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill     (fill_lvl),
        .pkt_cnt  (pkt_cnt),
        .fwd_thr  (ct_thr),
        .hd_eop   (out_eop),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .rd_en    (rd_en)
    );

endmodule

// File: rtl/pkt_fifo_chk.sv
module pkt_fifo_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int FILL_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_eop,
    input logic              in_err,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_eop,
    input logic [DATA_W-1:0] out_data,
    input logic [FILL_W-1:0] fill,
    input logic [23:0]       ct_thr,
    input logic              drop_en,
    input logic              csr_write
);

    assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(DEPTH));

    assert_quiet_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0) |-> !out_valid);

    assert_hold_under_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !csr_write)
        |=> (out_valid && $stable(out_data) && $stable(out_eop)));

    assert_packet_continues_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_eop) |=> ((fill == '0) || out_valid));

    assert_drop_shrinks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_eop && in_err && drop_en && (ct_thr == '0))
        |=> (fill <= $past(fill)));

endmodule

bind pkt_fifo pkt_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .FILL_W(FILL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_eop   (in_eop),
    .in_err   (in_err),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_eop  (out_eop),
    .out_data (out_data),
    .fill     (fill_lvl),
    .ct_thr   (ct_thr),
    .drop_en  (drop_en),
    .csr_write(csr_write)
);

// File: tb/pkt_fifo_bench.sv
`timescale 1ns/100ps
module pkt_fifo_bench;

    localparam int DATA_W = 8;
    localparam int DEPTH  = 8;
    localparam int WD     = 100000;

    typedef struct packed {
        logic              x;
        logic              e;
        logic              s;
        logic [DATA_W-1:0] d;
    } beat_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_ready;
    logic              out_valid, out_sop, out_eop, out_err;
    logic              out_ready = 1'b0;
    logic [DATA_W-1:0] out_data;
    logic              almost_full, almost_empty;
    logic [2:0]        csr_addr = 3'd0;
    logic              csr_write = 1'b0;
    logic [31:0]       csr_wdata = '0;
    logic [31:0]       csr_rdata;

    always #2.5 clk = ~clk;

    pkt_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_pkt_fifo (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err),
        .almost_full(almost_full), .almost_empty(almost_empty),
        .csr_addr(csr_addr), .csr_write(csr_write),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    int err_eops = 0;
    int sink_mode = 1;
    int cyc = 0;

    // reference model state
    beat_t       q[$];
    bit          m_flow;
    int          m_pkts, m_part;
    logic [23:0] m_af, m_ae, m_ct;
    logic        m_drop;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit model_valid();
        if (q.size() == 0) return 1'b0;
        if (m_flow) return 1'b1;
        if (m_ct == 0) return (m_pkts > 0);
        return (q.size() >= int'(m_ct));
    endfunction

    function automatic logic [31:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0:    return 32'(q.size());
            3'd2:    return 32'(m_af);
            3'd3:    return 32'(m_ae);
            3'd4:    return 32'(m_ct);
            3'd5:    return 32'(m_drop);
            default: return 32'd0;
        endcase
    endfunction

    // model update on each rising edge from stable inputs
    bit    mv, mwr;
    beat_t bb;
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_flow = 0; m_pkts = 0; m_part = 0;
            m_af = 24'(DEPTH - 1); m_ae = '0; m_ct = '0; m_drop = 1'b0;
        end else begin
            mv  = model_valid();
            mwr = in_valid && (q.size() < DEPTH);
            if (mv && out_ready) begin
                bb = q.pop_front();
                if (bb.e) begin m_pkts--; m_flow = 0; end
                else m_flow = 1;
            end
            if (mwr) begin
                if (in_eop && in_err && m_drop && (m_ct == 0)) begin
                    repeat (m_part) void'(q.pop_back());
                    m_part = 0;
                end else begin
                    q.push_back({in_err, in_eop, in_sop, in_data});
                    if (in_eop) begin m_pkts++; m_part = 0; end
                    else m_part++;
                end
            end
            if (csr_write) begin
                case (csr_addr)
                    3'd2: m_af   = csr_wdata[23:0];
                    3'd3: m_ae   = csr_wdata[23:0];
                    3'd4: m_ct   = csr_wdata[23:0];
                    3'd5: m_drop = csr_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    int    sz;
    bit    ev;
    string tg;
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            sz = q.size();
            ev = model_valid();
            check("R4 in_ready", 32'(in_ready), 32'(sz < DEPTH));
            tg = m_flow ? "R8 out_valid" : ((m_ct == 0) ? "R6 out_valid" : "R7 out_valid");
            check(tg, 32'(out_valid), 32'(ev));
            if (ev && out_valid)
                check("R5 head beat", 32'({out_err, out_eop, out_sop, out_data}),
                      32'({q[0].x, q[0].e, q[0].s, q[0].d}));
            check("R3 almost_full", 32'(almost_full), 32'(sz >= int'(m_af)));
            check("R3 almost_empty", 32'(almost_empty), 32'(sz <= int'(m_ae)));
            case (csr_addr)
                3'd0:       tg = "R1 level read";
                3'd2, 3'd3: tg = "R2 level regs";
                3'd4, 3'd5: tg = "R11 mode regs";
                default:    tg = "R10 spare read";
            endcase
            check(tg, csr_rdata, model_rd(csr_addr));
            if (out_valid && out_ready && out_eop && out_err) err_eops++;
        end
    end

    always @(negedge clk) begin
        cyc++;
        case (sink_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = 1'b0;
            default: out_ready = ((cyc % 3) != 0);
        endcase
    end

    task automatic send_beat(input logic [7:0] d, input logic s, input logic e, input logic x);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e; in_err = x;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_err = 1'b0;
    endtask

    task automatic send_pkt(input int len, input int base, input bit err, input int gap);
        for (int i = 0; i < len; i++) begin
            send_beat(8'(base + i), i == 0, i == len - 1, err && (i == len - 1));
            if (gap > 0 && i != len - 1) begin
                idle();
                repeat (gap - 1) @(negedge clk);
            end
        end
        idle();
    endtask

    task automatic csr_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_write = 1'b1;
        @(negedge clk);
        csr_write = 1'b0;
    endtask

    task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        csr_addr = a;
        #1;
        check(tag, csr_rdata, e);
    endtask

    task automatic wait_empty();
        for (int k = 0; k < 500 && q.size() != 0; k++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual still running expected finished");
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    int e0;
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // reset state: R1 R2 R10 R11
        @(negedge clk); #1;
        check("R4 ready after reset", 32'(in_ready), 32'd1);
        check("R6 no output after reset", 32'(out_valid), 32'd0);
        expect_rd(3'd0, 32'd0, "R1 reset level");
        expect_rd(3'd2, 32'(DEPTH - 1), "R2 reset high level");
        expect_rd(3'd3, 32'd0, "R2 reset low level");
        expect_rd(3'd4, 32'd0, "R11 reset threshold");
        expect_rd(3'd5, 32'd0, "R11 reset drop");
        expect_rd(3'd1, 32'd0, "R10 spare word");

        // store-and-forward gating: R6
        sink_mode = 1;
        send_beat(8'hA0, 1'b1, 1'b0, 1'b0);
        send_beat(8'hA1, 1'b0, 1'b0, 1'b0);
        idle(); #1;
        check("R6 partial packet withheld", 32'(out_valid), 32'd0);
        send_beat(8'hA2, 1'b0, 1'b1, 1'b0);
        idle(); #1;
        check("R6 complete packet offered", 32'(out_valid), 32'd1);
        sink_mode = 0;
        wait_empty();

        // full boundary and flags: R4 R3 R1 R2
        sink_mode = 1;
        send_pkt(4, 8'h10, 1'b0, 0);
        send_pkt(4, 8'h18, 1'b0, 0);
        #1;
        check("R4 ready low when full", 32'(in_ready), 32'd0);
        check("R3 almost_full at reset level", 32'(almost_full), 32'd1);
        expect_rd(3'd0, 32'(DEPTH), "R1 full level");
        csr_wr(3'd2, 32'hFF00_0009);
        #1;
        check("R3 almost_full above level", 32'(almost_full), 32'd0);
        expect_rd(3'd2, 32'd9, "R2 high level readback");
        csr_wr(3'd3, 32'd3);
        expect_rd(3'd3, 32'd3, "R2 low level readback");
        sink_mode = 2;
        wait_empty();

        // cut-through start and continuation: R7 R8
        csr_wr(3'd4, 32'd3);
        sink_mode = 1;
        send_beat(8'h40, 1'b1, 1'b0, 1'b0);
        send_beat(8'h41, 1'b0, 1'b0, 1'b0);
        idle(); #1;
        check("R7 below threshold withheld", 32'(out_valid), 32'd0);
        send_beat(8'h42, 1'b0, 1'b0, 1'b0);
        idle(); #1;
        check("R7 threshold reached", 32'(out_valid), 32'd1);
        sink_mode = 0;
        wait_empty();
        send_beat(8'h43, 1'b0, 1'b0, 1'b0);
        idle(); #1;
        check("R8 mid-packet beat below threshold", 32'(out_valid), 32'd1);
        send_beat(8'h44, 1'b0, 1'b1, 1'b0);
        idle();
        wait_empty();

        // cut-through ignores the drop switch: R9
        csr_wr(3'd5, 32'd1);
        csr_wr(3'd4, 32'd2);
        e0 = err_eops;
        send_pkt(3, 8'h50, 1'b1, 1);
        wait_empty();
        check("R9 errored packet passes in cut-through", 32'(err_eops), 32'(e0 + 1));

        // store-and-forward drop: R9
        csr_wr(3'd4, 32'd0);
        sink_mode = 1;
        send_pkt(3, 8'h60, 1'b0, 0);
        send_pkt(4, 8'h70, 1'b1, 0);
        send_pkt(2, 8'h80, 1'b0, 0);
        expect_rd(3'd0, 32'd5, "R9 errored packet removed");
        e0 = err_eops;
        sink_mode = 0;
        wait_empty();
        check("R9 no errored end delivered", 32'(err_eops), 32'(e0));

        // ignored writes and spare words: R10 R11
        sink_mode = 1;
        send_pkt(2, 8'h90, 1'b0, 0);
        csr_wr(3'd0, 32'h55);
        csr_wr(3'd1, 32'hAB);
        csr_wr(3'd6, 32'h77);
        expect_rd(3'd1, 32'd0, "R10 spare reads zero");
        expect_rd(3'd0, 32'd2, "R10 level unchanged by write");
        expect_rd(3'd6, 32'd0, "R10 upper word reads zero");
        expect_rd(3'd2, 32'd9, "R10 high level untouched");
        csr_wr(3'd5, 32'hFFFF_FFFE);
        expect_rd(3'd5, 32'd0, "R11 drop bit only");
        csr_wr(3'd5, 32'd3);
        expect_rd(3'd5, 32'd1, "R11 drop readback");
        csr_wr(3'd4, 32'h0012_3456);
        expect_rd(3'd4, 32'h0012_3456, "R11 threshold readback");
        csr_wr(3'd4, 32'd0);
        csr_wr(3'd5, 32'd0);
        sink_mode = 0;
        wait_empty();

        // mixed traffic under backpressure in both modes: R5
        sink_mode = 2;
        for (int p = 1; p <= 5; p++) send_pkt(p, p * 16, 1'b0, p % 2);
        wait_empty();
        csr_wr(3'd4, 32'd2);
        for (int p = 1; p <= 5; p++) send_pkt(p, 8'h80 + p * 8, p == 3, (p + 1) % 2);
        wait_empty();
        csr_wr(3'd4, 32'd0);
        csr_wr(3'd5, 32'd1);
        for (int p = 5; p >= 1; p--) send_pkt(p, 8'hC0 + p * 4, p == 2, 0);
        wait_empty();
        #1;
        check("R5 drained at end", 32'(out_valid), 32'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule